// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Controller

This block sits between a simple request port and an asynchronous DRAM that has a multiplexed address bus. Each request carries a row-and-column address, a write flag and write data. The controller splits the address into a row half and a column half. It drives the two halves onto the DRAM pins in turn, and it sequences the four active-low strobes: row select, column select, write enable and output enable. All timing is counted in controller clock cycles.

After an access, the row stays open. A later request to the same row is served with column strobes only. A request to a different row first closes the page: the row strobe is held high for the precharge time before the new row opens. An internal scheduler asks for a refresh at a fixed interval. A refresh takes priority over new requests and closes any open row. It is carried out with the column strobe falling one cycle before the row strobe, so the DRAM takes the row from its own counter and ignores the address pins.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset all four strobes are high, `dram_dq_oe` and `rd_valid` are low, and `req_ready` is high.
- R2: When no row is open, an accepted request opens its row. The row strobe falls in the cycle after acceptance, with the row half (`req_addr[ROW_W+COL_W-1:COL_W]`) on `dram_addr`, and stays low for `T_RCD` cycles. Next comes one cycle with the column half (`req_addr[COL_W-1:0]`) on the bus and the column strobe high. The column strobe then falls. With the defaults, the column strobe falls 4 cycles after the row strobe, and the access spans 5 cycles.
- R3: A request to the open row is accepted while the page idles, or in the last cycle of a column strobe. The row strobe stays low, and the column strobe falls in the second cycle after acceptance. Back-to-back hits are therefore 2 cycles apart.
- R4: A request to a different row is not accepted until the row strobe has been high for `T_RP` cycles plus one idle cycle. The row strobe is high for 3 cycles with the defaults.
- R5: On a write, `dram_we_n` goes low and `dram_dq_oe` goes high with the write data in the column-setup cycle, one cycle before the column strobe falls. Both hold until the column strobe rises.
- R6: `dram_oe_n` is low only during the column strobe of a read, with `dram_we_n` high. The read data on `dram_dq_in` at the end of the strobe appears on `rd_data`, and `rd_valid` is high for exactly the one cycle that follows.
- R7: A refresh lowers the column strobe with the row strobe high, and lowers the row strobe one cycle later. Both stay low for `T_REF_RAS` cycles, and then the row strobe is held high for at least `T_RP` cycles.
- R8: A refresh is requested every `REF_INTERVAL` cycles. While one is pending, `req_ready` is low, any open row is closed, and the refresh runs before the next request.
- R9: `dram_dq_oe` is high only while `dram_we_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Row half above column half |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | DW | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed DRAM address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DW | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | DW | Data from the DRAM |

## Verification
The assertions take for granted that requesters keep `req_addr`, `req_write` and `req_wdata` stable while `req_valid` is high and `req_ready` is low. They also assume that `REF_INTERVAL` is well above the length of one refresh plus one access, so that pending refreshes never pile up. The bench drives every request through one task that holds all request fields until acceptance. It sets the refresh interval to 60 cycles, well above the roughly 15 cycles a refresh and an access take together. Requests mix page hits, row misses, unwritten locations and long idle gaps, so refreshes land both on open pages and on a closed bank.

// File: rtl/fpm_pkg.sv
// Shared types for the fast-page DRAM controller.
// Assumes: nothing beyond IEEE 1800-2017.
package fpm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,  // bank precharged, row strobe high
        ST_ACT,   // row strobe low, row address on bus
        ST_CSET,  // column address setup, column strobe high
        ST_STRB,  // column strobe low
        ST_PAGE,  // row open, waiting
        ST_PRE,   // row strobe high for precharge
        ST_RCAS,  // refresh: column strobe low first
        ST_RRAS   // refresh: both strobes low
    } fpm_state_e;
endpackage

// File: rtl/fpm_wait_timer.sv
// Down-counter that times how long a state lasts.
// The controller loads (length-1) on entry and leaves the state when done is high.
// Assumes: load is pulsed only on state transitions.
module fpm_wait_timer #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    // Load on entry, then count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R2: while not reloaded, a nonzero count drops by exactly one per cycle.
    a_r2_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fpm_refresh_sched.sv
// Raises a sticky refresh request every INTERVAL cycles and clears it on ack.
// Assumes: INTERVAL is longer than one refresh plus one access.
module fpm_refresh_sched #(
    parameter int INTERVAL = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic due
);
    localparam int CW = $clog2(INTERVAL + 1);
    logic [CW-1:0] cnt_q;
    logic          due_q;

    // Free-running interval counter. A wrap sets the request and ack clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            due_q <= 1'b0;
        end else begin
            if (cnt_q == CW'(INTERVAL - 1)) begin
                cnt_q <= '0;
                due_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (ack) due_q <= 1'b0;
            end
        end
    end

    assign due = due_q;

    // R8: a pending refresh stays pending until it is acknowledged.
    a_r8_due_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (due_q && !ack) |=> due_q);
endmodule

// File: rtl/fpm_dram_ctrl.sv
// Fast-page-mode controller for an asynchronous multiplexed-address DRAM.
// Keeps the row open between hits and closes it on a miss or a refresh.
// Refreshes with the column strobe falling before the row strobe.
// Assumes: request fields stay stable while valid is high and ready is low.
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int ROW_W        = 8,
    parameter int COL_W        = 8,
    parameter int DW           = 16,
    parameter int T_RCD        = 3,
    parameter int T_CAS        = 1,
    parameter int T_RP         = 2,
    parameter int T_REF_RAS    = 3,
    parameter int REF_INTERVAL = 780
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DW-1:0]          req_wdata,
    output logic                   rd_valid,
    output logic [DW-1:0]          rd_data,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic                   dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [DW-1:0]          dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DW-1:0]          dram_dq_in
);
    localparam int MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int TM_A  = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int TM_B  = (T_CAS > T_REF_RAS) ? T_CAS : T_REF_RAS;
    localparam int TMAX  = (TM_A > TM_B) ? TM_A : TM_B;
    localparam int TMR_W = $clog2(TMAX + 1);
    localparam int RPC_W = $clog2(T_RP + 2);

    fpm_state_e        state_q, state_d;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              wr_q;
    logic [DW-1:0]     wdata_q;
    logic              rd_valid_q;
    logic [DW-1:0]     rd_data_q;
    logic              tmr_load, tmr_done;
    logic [TMR_W-1:0]  tmr_val;
    logic              ref_due, ref_ack;
    logic              hit, accept;
    logic [ROW_W-1:0]  req_row;
    logic [COL_W-1:0]  req_col;

    assign req_row = req_addr[ROW_W+COL_W-1:COL_W];
    assign req_col = req_addr[COL_W-1:0];
    assign hit     = (req_row == row_q);
    assign ref_ack = (state_q == ST_RCAS);

    fpm_wait_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done));

    fpm_refresh_sched #(.INTERVAL(REF_INTERVAL)) u_refresh (
        .clk(clk), .rst_n(rst_n), .ack(ref_ack), .due(ref_due));

    // Ready: idle bank, idle page on a hit, or last strobe cycle on a hit; never with refresh due.
    always_comb begin
        case (state_q)
            ST_IDLE: req_ready = !ref_due;
            ST_PAGE: req_ready = !ref_due && hit;
            ST_STRB: req_ready = !ref_due && hit && tmr_done;
            default: req_ready = 1'b0;
        endcase
    end
    assign accept = req_valid && req_ready;

    // Next state and timer load.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE: begin
                if (ref_due) state_d = ST_RCAS;
                else if (req_valid) begin
                    state_d  = ST_ACT;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_RCD - 1);
                end
            end
            ST_ACT: if (tmr_done) state_d = ST_CSET;
            ST_CSET: begin
                state_d  = ST_STRB;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(T_CAS - 1);
            end
            ST_STRB, ST_PAGE: begin
                if (state_q == ST_PAGE || tmr_done) begin
                    if (accept) state_d = ST_CSET;
                    else if (ref_due || req_valid) begin
                        state_d  = ST_PRE;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(T_RP - 1);
                    end else state_d = ST_PAGE;
                end
            end
            ST_PRE: if (tmr_done) state_d = ST_IDLE;
            ST_RCAS: begin
                state_d  = ST_RRAS;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(T_REF_RAS - 1);
            end
            ST_RRAS: begin
                if (tmr_done) begin
                    state_d  = ST_PRE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_RP - 1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            row_q   <= '0;
            col_q   <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                row_q   <= req_row;
                col_q   <= req_col;
                wr_q    <= req_write;
                wdata_q <= req_wdata;
            end
        end
    end

    // Read capture at the end of a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= (state_q == ST_STRB) && tmr_done && !wr_q;
            if ((state_q == ST_STRB) && tmr_done && !wr_q) rd_data_q <= dram_dq_in;
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;

    // DRAM pins decoded from the state.
    assign dram_ras_n  = !(state_q inside {ST_ACT, ST_CSET, ST_STRB, ST_PAGE, ST_RRAS});
    assign dram_cas_n  = !(state_q inside {ST_STRB, ST_RCAS, ST_RRAS});
    assign dram_we_n   = !((state_q inside {ST_CSET, ST_STRB}) && wr_q);
    assign dram_oe_n   = !((state_q == ST_STRB) && !wr_q);
    assign dram_dq_oe  = (state_q inside {ST_CSET, ST_STRB}) && wr_q;
    assign dram_dq_out = wdata_q;
    assign dram_addr   = (state_q == ST_ACT) ? MA_W'(row_q) : MA_W'(col_q);

    // Counts how long the row strobe has been high (saturating), for the precharge check.
    logic [RPC_W-1:0] ras_hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                              ras_hi_cnt <= RPC_W'(T_RP);
        else if (!dram_ras_n)                    ras_hi_cnt <= '0;
        else if (ras_hi_cnt < RPC_W'(T_RP))      ras_hi_cnt <= ras_hi_cnt + 1'b1;
    end

    // R4 / R7: the row strobe never falls before T_RP high cycles.
    a_r4_precharge_min: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (ras_hi_cnt >= RPC_W'(T_RP)));
    // R5: on a write, write enable is already low when the column strobe falls.
    a_r5_we_before_cas: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n));
    // R6: output enable only in a read strobe.
    a_r6_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_oe_n |-> (dram_we_n && !dram_cas_n && !dram_ras_n));
    // R6: read data valid only right after output enable was low.
    a_r6_rd_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!dram_oe_n));
    // R7: a column strobe falling with the row strobe high is followed by a row strobe fall.
    a_r7_cbr_order: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && dram_ras_n) |=> $fell(dram_ras_n));
    // R8: no request is accepted while a refresh is pending.
    a_r8_refresh_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ref_due |-> !req_ready);
    // R9: data is driven only together with write enable.
    a_r9_dq_with_we: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> !dram_we_n);
endmodule

// File: tb/fpm_dram_ctrl_test.sv
// Scoreboard bench: the driver queues the expected access and read items,
// and monitors compare them against the behavioural DRAM and the read port.
module fpm_dram_ctrl_test;
    localparam int ROW_W = 8, COL_W = 8, DW = 16, AW = 16;
    localparam int T_RP = 2, REF_INT = 60;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rd_valid, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [DW-1:0] rd_data, dram_dq_out;
    logic [DW-1:0] dram_dq_in = '0;
    logic [7:0] dram_addr;

    fpm_dram_ctrl #(.REF_INTERVAL(REF_INT)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in));

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
        return a ^ 16'h5A3C;
    endfunction

    typedef struct { int acc; logic [ROW_W-1:0] row; logic [COL_W-1:0] col; logic wr; logic [DW-1:0] d; } acc_t;
    acc_t acc_q[$];
    logic [DW-1:0] rd_q[$];
    logic [DW-1:0] shadow [int];

    // Behavioural DRAM, evaluated at the falling clock edge.
    logic [DW-1:0] mem [int];
    logic [ROW_W-1:0] m_row = '0;
    logic [COL_W-1:0] m_col = '0;
    logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
    int hi_run = 0, last_run = 0, ras_fall_cyc = -1, last_cas_cyc = -1;
    int ref_cnt = 0, opens = 0, viol = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (dram_dq_oe && dram_we_n) viol++;
            if (!dram_ras_n && p_ras) begin
                if (!dram_cas_n) begin
                    ref_cnt++;
                    chk(!p_cas, "R7 column strobe before row strobe", {31'd0, p_cas}, 32'd0);
                end else begin
                    m_row = dram_addr[ROW_W-1:0];
                    opens++;
                    ras_fall_cyc = cyc;
                    last_run = hi_run;
                end
            end
            if (!dram_cas_n && p_cas && !dram_ras_n) begin
                acc_t it;
                m_col = dram_addr[COL_W-1:0];
                if (!dram_we_n) mem[int'({m_row, m_col})] = dram_dq_out;
                if (acc_q.size() == 0) chk(1'b0, "R2 unexpected column strobe", 32'd1, 32'd0);
                else begin
                    it = acc_q.pop_front();
                    chk({m_row, m_col} == {it.row, it.col}, "R2 row/column address",
                        {16'd0, m_row, m_col}, {16'd0, it.row, it.col});
                    if (ras_fall_cyc > last_cas_cyc) begin
                        chk(ras_fall_cyc == it.acc, "R2 row strobe after accept", ras_fall_cyc, it.acc);
                        chk(cyc == it.acc + 4, "R2 column strobe timing", cyc, it.acc + 4);
                    end else
                        chk(cyc == it.acc + 1, "R3 page-hit column strobe timing", cyc, it.acc + 1);
                    if (it.wr) begin
                        chk(!p_we && !dram_we_n, "R5 write enable before column strobe", {31'd0, p_we}, 32'd0);
                        chk(dram_dq_out == it.d && dram_dq_oe, "R5 write data", dram_dq_out, it.d);
                    end
                end
                last_cas_cyc = cyc;
            end
            if (!dram_ras_n && !dram_cas_n && dram_we_n && !dram_oe_n)
                dram_dq_in = mem.exists(int'({m_row, m_col})) ? mem[int'({m_row, m_col})]
                                                             : init_val({m_row, m_col});
            else dram_dq_in = '0;
            if (dram_ras_n) hi_run++; else hi_run = 0;
            p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n;
        end
    end

    // Read monitor: pops the expected data for each rd_valid pulse.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (rd_q.size() == 0) chk(1'b0, "R6 unexpected rd_valid", 32'd1, 32'd0);
            else begin
                logic [DW-1:0] e;
                e = rd_q.pop_front();
                chk(rd_data == e, "R6 read data", rd_data, e);
            end
        end
    end

    // Driver: presents one request, holds it until accepted, and queues the expected items.
    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        acc_t it;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        it.acc = cyc + 1; it.row = a[AW-1:COL_W]; it.col = a[COL_W-1:0]; it.wr = wr; it.d = d;
        acc_q.push_back(it);
        if (wr) shadow[int'(a)] = d;
        else rd_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : init_val(a));
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (acc_q.size() != 0 || rd_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int r0, o0;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes high",
            {28'd0, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 32'hF);
        chk(!dram_dq_oe && !rd_valid && req_ready, "R1 dq_oe/rd_valid/ready",
            {29'd0, dram_dq_oe, rd_valid, req_ready}, 32'h1);

        // R2/R3/R5/R6: open a row, then back-to-back page hits.
        access(1'b1, 16'h0105, 16'hBEEF);
        access(1'b1, 16'h0106, 16'h1234);
        access(1'b1, 16'h0107, 16'hA5A5);
        access(1'b0, 16'h0105, '0);
        access(1'b0, 16'h0106, '0);
        access(1'b0, 16'h0107, '0);
        drain();

        // R4: row miss closes the page for exactly T_RP + 1 cycles.
        access(1'b0, 16'h0203, '0);
        drain();
        chk(last_run == T_RP + 1, "R4 row strobe high time on miss", last_run, T_RP + 1);

        // Unwritten location and alternating rows.
        access(1'b0, 16'h7F00, '0);
        for (int i = 0; i < 6; i++) access(1'b1, AW'((i % 2 == 0 ? 16'h0300 : 16'h0400) + i), DW'(16'h1000 + i));
        for (int i = 0; i < 6; i++) access(1'b0, AW'((i % 2 == 0 ? 16'h0300 : 16'h0400) + i), '0);
        drain();

        // R8/R7: refreshes while idle with a page open, then the page must reopen.
        access(1'b0, 16'h0105, '0);
        drain();
        r0 = ref_cnt; o0 = opens;
        repeat (5 * REF_INT) @(negedge clk);
        chk(ref_cnt - r0 >= 4 && ref_cnt - r0 <= 6, "R8 refresh count over 5 intervals", ref_cnt - r0, 5);
        access(1'b0, 16'h0105, '0);
        drain();
        chk(opens == o0 + 1, "R8 refresh closed the open row", opens - o0, 1);

        // Mixed traffic across a few rows, crossing refreshes.
        for (int i = 0; i < 40; i++) access(i[0], AW'({i[3:2], 6'd0, 8'(i * 37)}), DW'(i * 911));
        for (int i = 0; i < 40; i++) access(1'b0, AW'({i[3:2], 6'd0, 8'(i * 37)}), '0);
        drain();

        chk(ref_cnt > 0, "R7 refreshes issued", ref_cnt, 1);
        chk(viol == 0, "R9 data driven without write enable", viol, 0);
        finish_run();
    end
endmodule